// File: doc/BRIEF.md
# Constant-Coefficient Block-Diagonal Linear Solver

This block produces the node-voltage vector of a linear network once per simulation time step. The network's inverse conductance matrix is computed offline and reaches the hardware as parameter constants. The source vector is formed in hardware: every component current contribution is tied to one network node, and the contributions that land on the same node are added together. Each solution entry is then a sum of products between constant matrix entries and source entries. There is no substitution stage and no divider.

The matrix is block diagonal. The node set is split into independent subsystems, and each subsystem gets its own multiply-add tree that uses only its own coefficients and its own source entries. A subsystem of n nodes therefore costs n² multiplies rather than a share of the full square. For example, a 12-node network split into two 4-node blocks and four single nodes needs 36 multiplies and 24 adds, against 144 and 132 for the undivided matrix.

All arithmetic is signed fixed point with a parameterised width and fraction. Source sums and multiply-add trees are combinational, so a new result follows the inputs without any control. The finished vector is captured into an output register on the time-step strobe.

Top module: `fixed_bdiag_solver`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), every entry of `x_out` is zero.
- R2: `x_out` loads the current solution only at a rising clock edge where `step` is high. At every other edge it holds its value, whatever `contrib` does. Contributions presented in the same cycle as `step` are the ones captured.
- R3: Source entry b_j is the exact sum of all contributions i whose map byte `CMAP[8i+7:8i]` equals j. That sum is then saturated to the W-bit signed range.
- R4: Solution entry x_i is the sum, over the nodes j of i's own block, of floor(A_ij·b_j / 2^F). This is within (block size) LSBs below the real-valued product A·b.
- R5: The outputs of one block do not change when only the contributions mapped to nodes of other blocks change.
- R6: When a solution sum exceeds the W-bit two's-complement range, the output is clamped to the largest or smallest representable value. It never wraps.
- R7: Every product is truncated toward negative infinity before summation. With A = 0.5, b = −1 LSB gives −1 LSB, b = +1 LSB gives 0, b = 3 LSB gives 1 LSB, and b = −3 LSB gives −2 LSB.
- R8: Layout rules:
  - Nodes are numbered consecutively block by block. Block k's size is `BLK_SIZES[8k+7:8k]`, starting at k = 0.
  - Coefficient element e sits at `COEFS[e*W +: W]`. Blocks are stored in order, each block row-major.
  - Contribution i is `contrib[i*W +: W]` and node i's result is `x_out[i*W +: W]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Time-step strobe; captures the solution at this edge |
| contrib | input | NCONTRIB*W | Signed fixed-point component current contributions |
| x_out | output | NNODE*W | Registered signed fixed-point solution vector |

## Verification
Source sums and product trees are combinational, so the only latency is the output register. A result is due at the first rising edge at which `step` is sampled high, and it stays until the next such edge. The bench drives stimulus and the strobe just after a falling edge and updates its expected vector at the capture edge. It compares every node on every following falling edge, half a period clear of any edge. Cycles without a strobe therefore check the hold behaviour, while the cycle after each strobe checks the new value, exactly for the truncation, saturation and block-isolation cases and within a block-size LSB tolerance for random vectors.

// File: rtl/bdiag_pkg.sv
package bdiag_pkg;

    // Maximum number of diagonal blocks described by a size vector.
    localparam int MAXB = 32;
    localparam int SZV  = MAXB * 8;

    function automatic int blk_size(logic [SZV-1:0] sz, int k);
        return int'(sz[k*8 +: 8]);
    endfunction

    // First node index of block k.
    function automatic int node_base(logic [SZV-1:0] sz, int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) acc += blk_size(sz, i);
        return acc;
    endfunction

    // First coefficient element of block k (row-major squares, block order).
    function automatic int coef_base(logic [SZV-1:0] sz, int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) acc += blk_size(sz, i) * blk_size(sz, i);
        return acc;
    endfunction

    function automatic int total_nodes(logic [SZV-1:0] sz, int nblk);
        return node_base(sz, nblk);
    endfunction

    function automatic int total_coefs(logic [SZV-1:0] sz, int nblk);
        return coef_base(sz, nblk);
    endfunction

endpackage

// File: rtl/bdiag_sat.sv
module bdiag_sat #(
    parameter int IW = 40,
    parameter int OW = 32
) (
    input  logic signed [IW-1:0] wide_in,
    output logic signed [OW-1:0] narrow_out
);
    localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
    localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

    logic [IW-OW:0] head;

    always_comb begin
        head = wide_in[IW-1:OW-1];
        if (head == '0 || head == '1) begin
            narrow_out = wide_in[OW-1:0];
        end else if (wide_in[IW-1]) begin
            narrow_out = MINV;
        end else begin
            narrow_out = MAXV;
        end
    end
endmodule

// File: rtl/bdiag_node_sum.sv
module bdiag_node_sum #(
    parameter int W        = 32,
    parameter int NNODE    = 12,
    parameter int NCONTRIB = 12,
    parameter logic [NCONTRIB*8-1:0] CMAP = '0
) (
    input  logic [NCONTRIB*W-1:0] contrib,
    output logic [NNODE*W-1:0]    b_vec
);
    localparam int AW = W + $clog2(NCONTRIB + 1) + 1;

    for (genvar n = 0; n < NNODE; n++) begin : g_node
        logic signed [AW-1:0] acc_d;

        always_comb begin
            acc_d = '0;
            for (int i = 0; i < NCONTRIB; i++) begin
                if (CMAP[i*8 +: 8] == 8'(n)) begin
                    acc_d = acc_d + AW'($signed(contrib[i*W +: W]));
                end
            end
        end

        bdiag_sat #(.IW(AW), .OW(W)) u_sat (
            .wide_in    (acc_d),
            .narrow_out (b_vec[n*W +: W])
        );
    end
endmodule

// File: rtl/bdiag_block_sop.sv
module bdiag_block_sop #(
    parameter int W = 32,
    parameter int F = 16,
    parameter int N = 4,
    parameter logic [N*N*W-1:0] COEFS = '0
) (
    input  logic [N*W-1:0] b_blk,
    output logic [N*W-1:0] x_blk
);
    localparam int PW = 2 * W;
    localparam int AW = PW + $clog2(N + 1);

    for (genvar r = 0; r < N; r++) begin : g_row
        logic signed [AW-1:0] sum_d;

        always_comb begin
            logic signed [PW-1:0] prod;
            logic signed [PW-1:0] trunc;
            sum_d = '0;
            for (int j = 0; j < N; j++) begin
                prod  = $signed(COEFS[(r*N + j)*W +: W]) * $signed(b_blk[j*W +: W]);
                trunc = prod >>> F;
                sum_d = sum_d + AW'(trunc);
            end
        end

        bdiag_sat #(.IW(AW), .OW(W)) u_sat (
            .wide_in    (sum_d),
            .narrow_out (x_blk[r*W +: W])
        );
    end
endmodule

// File: rtl/fixed_bdiag_solver.sv
module fixed_bdiag_solver
    import bdiag_pkg::*;
#(
    parameter int W        = 72,
    parameter int F        = 43,
    parameter int NBLK     = 6,
    parameter logic [NBLK*8-1:0] BLK_SIZES = {8'd1, 8'd1, 8'd1, 8'd1, 8'd4, 8'd4},
    parameter int NCONTRIB = 12,
    parameter logic [NCONTRIB*8-1:0] CMAP =
        {8'd11, 8'd10, 8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
    parameter int NNODE    = total_nodes(SZV'(BLK_SIZES), NBLK),
    parameter int NCOEF    = total_coefs(SZV'(BLK_SIZES), NBLK),
    parameter logic [NCOEF*W-1:0] COEFS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [NCONTRIB*W-1:0] contrib,
    output logic [NNODE*W-1:0]    x_out
);
    localparam logic [SZV-1:0] SZ = SZV'(BLK_SIZES);

    typedef struct packed {
        logic [NNODE*W-1:0] x;
    } state_t;

    state_t state_d, state_q;

    logic [NNODE*W-1:0] b_vec;
    logic [NNODE*W-1:0] x_comb;

    bdiag_node_sum #(
        .W        (W),
        .NNODE    (NNODE),
        .NCONTRIB (NCONTRIB),
        .CMAP     (CMAP)
    ) u_node_sum (
        .contrib (contrib),
        .b_vec   (b_vec)
    );

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        localparam int NB = node_base(SZ, k);
        localparam int NS = blk_size(SZ, k);
        localparam int CB = coef_base(SZ, k);

        bdiag_block_sop #(
            .W     (W),
            .F     (F),
            .N     (NS),
            .COEFS (COEFS[CB*W +: NS*NS*W])
        ) u_sop (
            .b_blk (b_vec[NB*W +: NS*W]),
            .x_blk (x_comb[NB*W +: NS*W])
        );
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            state_d.x = x_comb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign x_out = state_q.x;
endmodule

// File: rtl/bdiag_solver_chk.sv
module bdiag_solver_chk
    import bdiag_pkg::*;
#(
    parameter int W        = 32,
    parameter int NNODE    = 12,
    parameter int NCONTRIB = 12,
    parameter int NBLK     = 6,
    parameter logic [NBLK*8-1:0] BLK_SIZES = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step,
    input logic [NCONTRIB*W-1:0] contrib,
    input logic [NNODE*W-1:0]    b_vec,
    input logic [NNODE*W-1:0]    x_comb,
    input logic [NNODE*W-1:0]    x_out
);
    localparam logic [SZV-1:0] SZ = SZV'(BLK_SIZES);

    // R2: no strobe, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(x_out));

    // R2: strobe captures the combinational solution of that cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> x_out == $past(x_comb));

    // R3: all-zero contributions give an all-zero source vector
    a_r3_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
        contrib == '0 |-> b_vec == '0);

    // R4: a zero source vector gives a zero solution
    a_r4_zero_sol: assert property (@(posedge clk) disable iff (!rst_n)
        b_vec == '0 |-> x_comb == '0);

    // R5: a block whose sources hold keeps its solution
    for (genvar k = 0; k < NBLK; k++) begin : g_iso
        localparam int NB = node_base(SZ, k);
        localparam int NS = blk_size(SZ, k);
        a_r5_block_isolation: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(b_vec[NB*W +: NS*W]) |-> $stable(x_comb[NB*W +: NS*W]));
    end
endmodule

bind fixed_bdiag_solver bdiag_solver_chk #(
    .W         (W),
    .NNODE     (NNODE),
    .NCONTRIB  (NCONTRIB),
    .NBLK      (NBLK),
    .BLK_SIZES (BLK_SIZES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .contrib (contrib),
    .b_vec   (b_vec),
    .x_comb  (x_comb),
    .x_out   (x_out)
);

// File: tb/fixed_bdiag_solver_test.sv
`timescale 1ns/1ps
module fixed_bdiag_solver_test;
    localparam int W   = 32;
    localparam int F   = 16;
    localparam int NN  = 12;
    localparam int NC  = 16;
    localparam int NCO = 36;
    localparam longint XMAX = 64'sd2147483647;
    localparam longint XMIN = -64'sd2147483648;

    localparam logic [NC*8-1:0] TB_CMAP =
        {8'd11, 8'd9, 8'd5, 8'd0, 8'd11, 8'd10, 8'd9, 8'd8,
         8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0};

    // Full 12x12 inverse matrix, zero outside the diagonal blocks.
    function automatic longint coef_of(int r, int c);
        int br, bc;
        br = (r < 4) ? 0 : (r < 8) ? 1 : r;
        bc = (c < 4) ? 0 : (c < 8) ? 1 : c;
        if (br != bc) return 0;
        if (r < 8) return longint'((((r % 4) * 5 + (c % 4) * 3) % 7) - 3) * 16384
                          + ((r == c) ? 65536 : 0);
        case (r)
            8:       return 32768;
            9:       return 65536;
            10:      return -49152;
            default: return 131072;
        endcase
    endfunction

    function automatic logic [NCO*W-1:0] build_coefs();
        logic [NCO*W-1:0] v;
        int e;
        v = '0;
        e = 0;
        for (int base = 0; base < 8; base += 4)
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++) begin
                    v[e*W +: W] = 32'(coef_of(base + r, base + c));
                    e++;
                end
        for (int n = 8; n < 12; n++) begin
            v[e*W +: W] = 32'(coef_of(n, n));
            e++;
        end
        return v;
    endfunction

    localparam logic [NCO*W-1:0] TB_COEFS = build_coefs();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 1'b0;
    logic [NC*W-1:0] contrib;
    logic [NN*W-1:0] x_out;

    int cv [NC];
    real exp_x [NN];
    int checks = 0;
    int fails = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) contrib[i*W +: W] = cv[i];
    end

    fixed_bdiag_solver #(
        .W (W), .F (F), .NBLK (6),
        .BLK_SIZES ({8'd1, 8'd1, 8'd1, 8'd1, 8'd4, 8'd4}),
        .NCONTRIB (NC), .CMAP (TB_CMAP), .COEFS (TB_COEFS)
    ) uut (
        .clk (clk), .rst_n (rst_n), .step (step),
        .contrib (contrib), .x_out (x_out)
    );

    function automatic longint clampl(longint v);
        return (v > XMAX) ? XMAX : (v < XMIN) ? XMIN : v;
    endfunction

    function automatic longint b_of(int n);
        longint s;
        s = 0;
        for (int i = 0; i < NC; i++)
            if (int'(TB_CMAP[i*8 +: 8]) == n) s += longint'(cv[i]);
        return clampl(s);
    endfunction

    function automatic real model_x(int i);
        real s;
        s = 0.0;
        for (int j = 0; j < NN; j++)
            s += real'(coef_of(i, j)) * real'(b_of(j)) / 65536.0;
        if (s > real'(XMAX)) s = real'(XMAX);
        if (s < real'(XMIN)) s = real'(XMIN);
        return s;
    endfunction

    function automatic longint xo(int i);
        return longint'($signed(x_out[i*W +: W]));
    endfunction

    // Reference register: updated at the capture edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NN; i++) exp_x[i] = 0.0;
        end else if (step) begin
            for (int i = 0; i < NN; i++) exp_x[i] = model_x(i);
        end
    end

    // Every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < NN; i++) begin
                real d;
                d = real'(xo(i)) - exp_x[i];
                checks++;
                if (d > 4.0 || d < -4.0) begin
                    fails++;
                    $display("FAIL %s node %0d actual %0d expected %f", tag, i, xo(i), exp_x[i]);
                end
            end
        end
    end

    task automatic check_exact(string t, int n, longint e);
        checks++;
        if (xo(n) != e) begin
            fails++;
            $display("FAIL %s node %0d actual %0d expected %0d", t, n, xo(n), e);
        end
    endtask

    task automatic clear_cv();
        for (int i = 0; i < NC; i++) cv[i] = 0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    longint keep [NN];

    initial begin
        clear_cv();
        tag = "R1";
        repeat (3) @(negedge clk);
        for (int i = 0; i < NN; i++) check_exact("R1", i, 0);
        rst_n = 1'b1;

        // R4 R8: random vectors against the real-valued model
        tag = "R4 R8";
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < NC; i++) cv[i] = int'($urandom) >>> 12;
            do_step();
        end

        // R2: contributions move, no strobe, output holds
        tag = "R2";
        for (int i = 0; i < NN; i++) keep[i] = xo(i);
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < NC; i++) cv[i] = int'($urandom) >>> 10;
            @(negedge clk);
        end
        for (int i = 0; i < NN; i++) check_exact("R2", i, keep[i]);

        // R3: two contributions on the unity node 9
        tag = "R3";
        clear_cv();
        cv[9] = 1000; cv[14] = -300;
        do_step();
        check_exact("R3", 9, 700);
        cv[9] = 32'h7FFF_FFFF; cv[14] = 32'h7FFF_FFFF;
        do_step();
        check_exact("R3", 9, XMAX);
        cv[9] = 32'h8000_0000; cv[14] = 32'h8000_0000;
        do_step();
        check_exact("R3", 9, XMIN);

        // R6: coefficient 2.0 on node 11 overflows
        tag = "R6";
        clear_cv();
        cv[11] = 32'h6000_0000;
        do_step();
        check_exact("R6", 11, XMAX);
        cv[11] = -32'sh6000_0000;
        do_step();
        check_exact("R6", 11, XMIN);
        cv[11] = 1000; cv[15] = 234;
        do_step();
        check_exact("R6", 11, 2468);

        // R7: coefficient 0.5 on node 8, floor rounding
        tag = "R7";
        clear_cv();
        cv[8] = -1; do_step(); check_exact("R7", 8, -1);
        cv[8] = 1;  do_step(); check_exact("R7", 8, 0);
        cv[8] = 3;  do_step(); check_exact("R7", 8, 1);
        cv[8] = -3; do_step(); check_exact("R7", 8, -2);

        // R5: only block-1 contributions change
        tag = "R5";
        for (int i = 0; i < NC; i++) cv[i] = int'($urandom) >>> 12;
        do_step();
        for (int i = 0; i < NN; i++) keep[i] = xo(i);
        cv[4] = cv[4] + 5000; cv[5] = -cv[5]; cv[6] = 77; cv[7] = -9999; cv[13] = 12345;
        do_step();
        for (int i = 0; i < 4; i++) check_exact("R5", i, keep[i]);
        for (int i = 8; i < NN; i++) check_exact("R5", i, keep[i]);

        // R1: reset again clears the register
        tag = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NN; i++) check_exact("R1", i, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #4_000_000;
        done = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog expired in phase %s", tag);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule